// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Unit

This block computes a 16-bit cyclic redundancy check over a synchronous serial bit stream, one bit per accepted strobe. It works as a generator on the sending side and as a checker on the receiving side. Software picks one of two generator polynomials and presets the remainder to all ones or all zeros with a one-cycle command. Incoming bits are grouped into characters by a boundary strobe. Each finished character waits in a one-character holding stage. When the next boundary arrives, the per-character include flag seen in that cycle decides whether the held character is folded into the remainder. Software can therefore leave a character out of the check after that character has already arrived.

To send a check value, a request captures the remainder. The captured value goes out most significant bit first, one bit per accepted strobe. In bit-oriented framing the captured value is complemented before it is sent, and the receive check passes on the fixed residue 0x1D0F. In byte-oriented framing the value is sent as it stands and the check passes on zero. The serial input is a valid/ready stream. The strobes and the mode and command pins are plain levels.

Top module: `crcu_top`

## Requirements
- R1: After reset, `remainder` is 0x0000, `crc_busy` is 0 and `bit_ready` is 1.
- R2: Bits are folded into the remainder in arrival order, with the remainder's MSB as the feedback tap. `poly_sel`=0 selects x^16+x^15+x^2+1 (0x8005) and `poly_sel`=1 selects x^16+x^12+x^5+1 (0x1021). The ASCII string "123456789", sent MSB first with each byte its own character, gives 0x29B1 with `poly_sel`=1 and an all-ones preset. It gives 0xFEE8 with `poly_sel`=0 and an all-zeros preset.
- R3: A `preset_cmd` cycle loads the remainder with 0xFFFF when `preset_ones`=1 or 0x0000 when it is 0. The same cycle empties the collecting character, empties the held character and stops any CRC send.
- R4: `bit_ready` is low exactly in cycles with `preset_cmd` high. A bit offered in such a cycle is not accepted and never reaches the remainder.
- R5: A `char_end` cycle moves the collecting character into the holding stage. In that same cycle it folds the previously held character into the remainder only if `include_char` is 1. An excluded or empty held character leaves the remainder unchanged.
- R6: A character holds at most CHAR_BITS (8) bits. Further bits before the boundary are dropped. A bit accepted in the same cycle as `char_end` becomes the first bit of the next character.
- R7: A `send_crc` cycle captures the remainder as it was before that edge. The capture is complemented when `frame_mode`=1 (bit-oriented) and used as is when `frame_mode`=0. `crc_busy` then goes high and `crc_bit` shows the captured bits MSB first. Each accepted bit advances one position, and after 16 accepted bits `crc_busy` falls. Bits accepted while `crc_busy` is high do not enter any character.
- R8: `residue_ok` is 1 exactly when the remainder equals 0x1D0F with `frame_mode`=1, or 0x0000 with `frame_mode`=0. Take a message of whole characters with the all-ones preset and polynomial 0x1021, followed by the two bytes of its sent CRC (high byte first). With every character included and one final boundary, this makes `residue_ok` 1 in both modes.
- R9: A bit is accepted on a clock edge where `bit_valid` and `bit_ready` are both high. A bit held with `bit_valid` high is taken on the first such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Serial bit offered |
| bit_data | input | 1 | Serial bit value |
| bit_ready | output | 1 | Unit can take a bit this cycle |
| char_end | input | 1 | Character boundary strobe |
| include_char | input | 1 | Fold the held character in at this boundary |
| poly_sel | input | 1 | 0: 0x8005, 1: 0x1021 |
| preset_ones | input | 1 | Preset value: 1 all ones, 0 all zeros |
| preset_cmd | input | 1 | Load preset and clear character stages |
| frame_mode | input | 1 | 1 bit-oriented (complemented send, residue 0x1D0F), 0 byte-oriented |
| send_crc | input | 1 | Capture remainder and start serial send |
| remainder | output | 16 | Current CRC remainder |
| crc_bit | output | 1 | Current serial CRC bit |
| crc_busy | output | 1 | Serial CRC send in progress |
| residue_ok | output | 1 | Remainder matches the mode's check value |

## Verification
A character's bits show up in `remainder` only on the edge of the boundary after the one that closed it. The bench therefore compares the remainder one clock edge after every boundary pulse, against a transaction model that applies each include flag one character late. `preset_cmd` and `send_crc` take effect on the edge where they are sampled, so the remainder, `crc_busy` and the first `crc_bit` are checked right after that edge. Each later `crc_bit` is sampled after the previous accepted strobe's edge and before the next one. `bit_ready` and `residue_ok` are combinational and are sampled within the cycle, away from the edge.

// File: rtl/crcu_pkg.sv
package crcu_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] POLY_A  = 16'h8005;
  localparam logic [CRC_W-1:0] POLY_B  = 16'h1021;
  localparam logic [CRC_W-1:0] RESIDUE = 16'h1D0F;

  typedef enum logic {SEL_POLY_A = 1'b0, SEL_POLY_B = 1'b1} poly_e;

  function automatic logic [CRC_W-1:0] fold_bit(input logic [CRC_W-1:0] r,
                                                input logic d,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = r[CRC_W-1] ^ d;
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/crcu_collect.sv
module crcu_collect #(
  parameter int CHAR_BITS = 8,
  localparam int LEN_W = $clog2(CHAR_BITS + 1),
  localparam int IDX_W = (CHAR_BITS > 1) ? $clog2(CHAR_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 take_i,
  input  logic                 bit_i,
  input  logic                 close_i,
  output logic [CHAR_BITS-1:0] bits_o,
  output logic [LEN_W-1:0]     len_o
);
  logic [CHAR_BITS-1:0] bits_q, bits_n;
  logic [LEN_W-1:0]     cnt_q, cnt_n;

  always_comb begin
    bits_n = bits_q;
    cnt_n  = cnt_q;
    if (close_i) begin
      bits_n = '0;
      cnt_n  = '0;
      if (take_i) begin
        bits_n[0] = bit_i;
        cnt_n     = LEN_W'(1);
      end
    end else if (take_i && (cnt_q < LEN_W'(CHAR_BITS))) begin
      bits_n[cnt_q[IDX_W-1:0]] = bit_i;
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else begin
      bits_q <= bits_n;
      cnt_q  <= cnt_n;
    end
  end

  assign bits_o = bits_q;
  assign len_o  = cnt_q;

  // R6
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN_W'(CHAR_BITS));

  // R3
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/crcu_hold.sv
module crcu_hold #(
  parameter int CHAR_BITS = 8,
  localparam int LEN_W = $clog2(CHAR_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 close_i,
  input  logic                 include_i,
  input  logic [CHAR_BITS-1:0] in_bits_i,
  input  logic [LEN_W-1:0]     in_len_i,
  output logic                 commit_o,
  output logic [CHAR_BITS-1:0] held_bits_o,
  output logic [LEN_W-1:0]     held_len_o
);
  logic [CHAR_BITS-1:0] held_q;
  logic [LEN_W-1:0]     hlen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      hlen_q <= '0;
    end else if (clear_i) begin
      held_q <= '0;
      hlen_q <= '0;
    end else if (close_i) begin
      held_q <= in_bits_i;
      hlen_q <= in_len_i;
    end
  end

  assign commit_o    = close_i && include_i && (hlen_q != '0) && !clear_i;
  assign held_bits_o = held_q;
  assign held_len_o  = hlen_q;

  // R5
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_i && !clear_i) |=> (hlen_q == $past(in_len_i)));
endmodule

// File: rtl/crcu_rem.sv
module crcu_rem #(
  parameter int CHAR_BITS = 8,
  localparam int LEN_W = $clog2(CHAR_BITS + 1),
  localparam int CW = crcu_pkg::CRC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 preset_ones_i,
  input  logic                 poly_sel_i,
  input  logic                 commit_i,
  input  logic [CHAR_BITS-1:0] bits_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic [CW-1:0]        rem_o
);
  logic [CW-1:0] rem_q, folded, poly;

  assign poly = (crcu_pkg::poly_e'(poly_sel_i) == crcu_pkg::SEL_POLY_B)
                ? crcu_pkg::POLY_B : crcu_pkg::POLY_A;

  always_comb begin
    folded = rem_q;
    for (int i = 0; i < CHAR_BITS; i++) begin
      if (i < int'(len_i)) folded = crcu_pkg::fold_bit(folded, bits_i[i], poly);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rem_q <= '0;
    else if (clear_i)  rem_q <= preset_ones_i ? '1 : '0;
    else if (commit_i) rem_q <= folded;
  end

  assign rem_o = rem_q;

  // R3
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (rem_q == ($past(preset_ones_i) ? {CW{1'b1}} : {CW{1'b0}})));

  // R5
  rem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !commit_i) |=> $stable(rem_q));
endmodule

// File: rtl/crcu_tx.sv
module crcu_tx #(
  localparam int CW = crcu_pkg::CRC_W,
  localparam int CNT_W = $clog2(CW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic          invert_i,
  input  logic [CW-1:0] snap_i,
  input  logic          step_i,
  output logic          bit_o,
  output logic          busy_o
);
  logic [CW-1:0]    sh_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (clear_i) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= invert_i ? ~snap_i : snap_i;
      left_q <= CNT_W'(CW);
    end else if (step_i && (left_q != '0)) begin
      sh_q   <= {sh_q[CW-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o  = sh_q[CW-1];
  assign busy_o = (left_q != '0);

  // R7
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |=> busy_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !load_i && !step_i) |=> ($stable(bit_o) && $stable(busy_o)));

  // R7
  left_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= CNT_W'(CW));
endmodule

// File: rtl/crcu_top.sv
module crcu_top #(
  parameter int CHAR_BITS = 8,
  localparam int LEN_W = $clog2(CHAR_BITS + 1),
  localparam int CW = crcu_pkg::CRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          bit_data,
  output logic          bit_ready,
  input  logic          char_end,
  input  logic          include_char,
  input  logic          poly_sel,
  input  logic          preset_ones,
  input  logic          preset_cmd,
  input  logic          frame_mode,
  input  logic          send_crc,
  output logic [CW-1:0] remainder,
  output logic          crc_bit,
  output logic          crc_busy,
  output logic          residue_ok
);
  logic                 accept, take, step, close;
  logic [CHAR_BITS-1:0] col_bits, held_bits;
  logic [LEN_W-1:0]     col_len, held_len;
  logic                 commit;
  logic [CW-1:0]        rem;

  assign bit_ready = !preset_cmd;
  assign accept    = bit_valid && bit_ready;
  assign take      = accept && !crc_busy;
  assign step      = accept && crc_busy;
  assign close     = char_end && !preset_cmd;

  crcu_collect #(.CHAR_BITS(CHAR_BITS)) collect_i (
    .clk(clk), .rst_n(rst_n), .clear_i(preset_cmd), .take_i(take),
    .bit_i(bit_data), .close_i(close), .bits_o(col_bits), .len_o(col_len)
  );

  crcu_hold #(.CHAR_BITS(CHAR_BITS)) hold_i (
    .clk(clk), .rst_n(rst_n), .clear_i(preset_cmd), .close_i(close),
    .include_i(include_char), .in_bits_i(col_bits), .in_len_i(col_len),
    .commit_o(commit), .held_bits_o(held_bits), .held_len_o(held_len)
  );

  crcu_rem #(.CHAR_BITS(CHAR_BITS)) rem_i (
    .clk(clk), .rst_n(rst_n), .clear_i(preset_cmd), .preset_ones_i(preset_ones),
    .poly_sel_i(poly_sel), .commit_i(commit), .bits_i(held_bits),
    .len_i(held_len), .rem_o(rem)
  );

  crcu_tx tx_i (
    .clk(clk), .rst_n(rst_n), .clear_i(preset_cmd), .load_i(send_crc),
    .invert_i(frame_mode), .snap_i(rem), .step_i(step),
    .bit_o(crc_bit), .busy_o(crc_busy)
  );

  assign remainder  = rem;
  assign residue_ok = (rem == (frame_mode ? crcu_pkg::RESIDUE : {CW{1'b0}}));

  // R4
  blocked_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_cmd && bit_valid) |=> (col_len == '0));

  // R7
  busy_no_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_busy && !char_end && !preset_cmd) |=> $stable(col_len));
endmodule

// File: tb/crcu_top_tb_top.sv
module crcu_top_tb_top;
  logic clk = 0, rst_n = 0;
  logic bit_valid = 0, bit_data = 0, char_end = 0, include_char = 0;
  logic poly_sel = 0, preset_ones = 0, preset_cmd = 0, frame_mode = 0, send_crc = 0;
  logic bit_ready, crc_bit, crc_busy, residue_ok;
  logic [15:0] remainder;

  int errors = 0, checks = 0;
  logic [15:0] m_rem;
  logic [7:0]  m_cur, m_held;
  int m_cur_n, m_held_n, m_tx_left;

  always #4 clk = ~clk;

  crcu_top dut_i (.*);

  function automatic logic [15:0] fold(input logic [15:0] r, input logic d, input logic ps);
    logic [15:0] p;
    p = ps ? 16'h1021 : 16'h8005;
    return {r[14:0], 1'b0} ^ ((r[15] ^ d) ? p : 16'h0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    bit_valid = 0; char_end = 0; include_char = 0; preset_cmd = 0; send_crc = 0;
  endtask

  task automatic put_bit(input logic b);
    bit_valid = 1; bit_data = b;
    tick();
    if (m_tx_left > 0) m_tx_left--;
    else if (m_cur_n < 8) begin m_cur[m_cur_n] = b; m_cur_n++; end
  endtask

  task automatic model_close(input logic inc);
    if (inc) for (int i = 0; i < m_held_n; i++) m_rem = fold(m_rem, m_held[i], poly_sel);
    m_held = m_cur; m_held_n = m_cur_n; m_cur = 0; m_cur_n = 0;
  endtask

  task automatic close(input logic inc);
    char_end = 1; include_char = inc;
    tick();
    model_close(inc);
  endtask

  task automatic do_preset(input logic ones);
    preset_cmd = 1; preset_ones = ones;
    tick();
    m_rem = ones ? 16'hFFFF : 16'h0;
    m_cur = 0; m_cur_n = 0; m_held = 0; m_held_n = 0; m_tx_left = 0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic send_and_grab(output logic [15:0] w);
    send_crc = 1;
    tick();
    m_tx_left = 16;
    chk("R7 busy after send", crc_busy, 1);
    for (int i = 15; i >= 0; i--) begin
      w[i] = crc_bit;
      put_bit(1'($urandom));
    end
    chk("R7 busy falls after 16", crc_busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] msg [0:8];
    logic [15:0] w, exp_w, saved;
    void'($urandom(32'd2024));
    m_rem = 0; m_cur = 0; m_held = 0; m_cur_n = 0; m_held_n = 0; m_tx_left = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 remainder", remainder, 16'h0);
    chk("R1 crc_busy", crc_busy, 0);
    chk("R1 bit_ready", bit_ready, 1);
    chk("R8 zero residue byte mode", residue_ok, 1);

    // R2 known vectors
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    poly_sel = 1; do_preset(1);
    chk("R3 preset ones", remainder, 16'hFFFF);
    for (int i = 0; i < 9; i++) begin put_byte(msg[i]); close(1); end
    close(1);
    chk("R2 ccitt vector", remainder, 16'h29B1);
    poly_sel = 0; do_preset(0);
    chk("R3 preset zeros", remainder, 16'h0);
    for (int i = 0; i < 9; i++) begin put_byte(msg[i]); close(1); end
    close(1);
    chk("R2 crc16 vector", remainder, 16'hFEE8);

    // R5 late include
    poly_sel = 1; do_preset(1);
    put_byte(8'hA5); close(1);
    chk("R5 held not folded yet", remainder, 16'hFFFF);
    put_byte(8'h3C); close(0);
    chk("R5 excluded held char", remainder, 16'hFFFF);
    close(1);
    chk("R5 included later char", remainder, m_rem);

    // R4 preset priority and ready
    preset_cmd = 1; preset_ones = 0; bit_valid = 1; bit_data = 1;
    #1 chk("R4 ready low during preset", bit_ready, 0);
    tick();
    m_rem = 0; m_cur = 0; m_cur_n = 0; m_held = 0; m_held_n = 0; m_tx_left = 0;
    put_byte(8'h81); close(1); close(1);
    chk("R4 blocked bit not taken", remainder, m_rem);

    // R9 held valid with gap cycles
    tick(); bit_valid = 0; tick();
    put_byte(8'h5A); close(1); close(1);
    chk("R9 accepted bits", remainder, m_rem);

    // R6 overlong char and same-cycle boundary bit
    for (int i = 0; i < 11; i++) put_bit(1'(i % 3));
    close(1);
    bit_valid = 1; bit_data = 1; char_end = 1; include_char = 1;
    tick();
    model_close(1); m_cur[0] = 1; m_cur_n = 1;
    for (int i = 0; i < 7; i++) put_bit(1'(i & 1));
    close(1); close(1);
    chk("R6 cap and boundary bit", remainder, m_rem);

    // R7 send in both modes, R8 residue
    for (int fm = 0; fm < 2; fm++) begin
      frame_mode = 1'(fm); poly_sel = 1; do_preset(1);
      for (int i = 0; i < 4; i++) begin msg[i] = 8'($urandom); put_byte(msg[i]); close(1); end
      close(1);
      saved = remainder;
      exp_w = fm ? ~m_rem : m_rem;
      send_and_grab(w);
      chk("R7 sent crc bits", w, exp_w);
      chk("R7 bits during send ignored", remainder, saved);
      close(1); close(1);
      chk("R7 no char gathered during send", remainder, saved);
      do_preset(1);
      for (int i = 0; i < 4; i++) begin put_byte(msg[i]); close(1); end
      put_byte(w[15:8]); close(1);
      put_byte(w[7:0]); close(1);
      close(1);
      chk("R8 residue_ok", residue_ok, 1);
      chk("R8 residue value", remainder, fm ? 16'h1D0F : 16'h0);
    end

    // random mix
    for (int it = 0; it < 150; it++) begin
      int n;
      if ($urandom % 10 == 0) begin
        do_preset(1'($urandom));
        chk("R3 random preset", remainder, m_rem);
      end else begin
        n = 1 + $urandom % 10;
        for (int k = 0; k < n; k++) begin
          if ($urandom % 5 == 0) tick();
          put_bit(1'($urandom));
        end
        poly_sel = 1'($urandom); frame_mode = 1'($urandom);
        close(1'($urandom));
        chk("R5 random remainder", remainder, m_rem);
        chk("R8 random residue flag", residue_ok,
            (m_rem == (frame_mode ? 16'h1D0F : 16'h0)));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule